// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 2-kbit non-volatile serial memory that a host reaches over a three-wire select/clock/data link with a separate serial output. A fast system clock oversamples the select, serial clock and serial data inputs. Each rising serial-clock edge is then handled as one protocol step. A static organization input sets the word size. It is either 256 words of 8 bits or 128 words of 16 bits. Both views share the same byte storage.

Each command begins with a start bit. Two opcode bits follow, then an address field and, for the two store commands, a data word. The block supports single-word reads with streaming continuation, word store and word clear, array-wide clear and array-wide fill, and a write-protection latch. Store-type commands are held pending until the select line drops. A self-timed programming interval, counted in system clocks, then begins. During that interval the serial output reports busy or ready whenever the host selects the block.

Top module: `uwire_eeprom`

## Requirements
- R1: A command begins at the first rising serial-clock edge that sees select high and data-in high. Rising edges with data-in low before that point have no effect.
- R2: The two bits after the start bit select the command: 10 read, 01 store word, 11 clear word. For 00, the next two bits are a sub-code: 11 unlock, 00 lock, 10 clear array, 01 fill array. The address field is 9 bits in 8-bit mode and 8 bits in 16-bit mode. In both cases its first bit is ignored.
- R3: On the rising edge that carries the last address bit of a read, the output drives a 0. Each following rising edge presents the next bit of the word, most significant bit first.
- R4: While select stays high, a read continues into the next address with no extra 0 bit. The last address wraps to address 0.
- R5: After reset the block is locked. Store and clear commands then change nothing and start no programming interval. Unlock lasts until a lock command or reset. Reads work in both states.
- R6: A store or clear takes effect only when select falls after the complete command has been shifted in. A command cut short by select falling is discarded.
- R7: Clear array sets every byte to FF. Fill array writes the data to every word. In 16-bit mode, even bytes take bits 15:8 and odd bytes take bits 7:0.
- R8: All bytes reset to FF. In 16-bit mode, word k consists of byte 2k (bits 15:8) and byte 2k+1 (bits 7:0).
- R9: A programming interval lasts PROG_CYCLES system clocks. While select is high during it, the output shows 0. After it ends, the output shows 1. Start bits arriving while it runs are ignored.
- R10: The ready/busy indication stays on the output across deselects. It is removed when a start bit is received and select then falls.
- R11: While select is low, the output enable is low and any command in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input |
| org_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects 8-bit words |
| sdo_o | output | 1 | Serial data output (read data or ready/busy) |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
Two functions can fall in the same cycle. A running programming interval may coincide with a new start bit, and each drives the serial output in its own way. The bench writes a byte and reselects the block while the interval is still counting. It then shifts in a complete read of an address whose stored value has its top bit set, and clocks one more edge. The output must still show busy (0) on that edge, where the data's leading 1 would otherwise appear. The bench also checks that the indication changes to ready (1) once the interval has expired.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_READ,
        ST_DONE
    } uwe_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_UNLOCK,
        OP_LOCK,
        OP_WIPE,
        OP_PUT,
        OP_WIPE_ALL,
        OP_PUT_ALL
    } uwe_op_e;

endpackage

// File: rtl/uwe_sync.sv
module uwe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/uwe_store.sv
module uwe_store #(
    parameter int BYTES = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wide,
    input  logic                     we,
    input  logic                     we_all,
    input  logic [$clog2(BYTES)-1:0] waddr,
    input  logic [15:0]              wdata,
    input  logic [$clog2(BYTES)-1:0] raddr,
    output logic [15:0]              rdata
);

    localparam int ADDR_W = $clog2(BYTES);

    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                if (we_all) begin
                    mem_q[i] <= (wide && (i % 2 == 0)) ? wdata[15:8] : wdata[7:0];
                end else if (we) begin
                    if (wide) begin
                        if (waddr[ADDR_W-2:0] == (ADDR_W-1)'(i >> 1))
                            mem_q[i] <= (i % 2 == 0) ? wdata[15:8] : wdata[7:0];
                    end else if (waddr == ADDR_W'(i)) begin
                        mem_q[i] <= wdata[7:0];
                    end
                end
            end
        end
    end

    always_comb begin
        if (wide)
            rdata = {mem_q[{raddr[ADDR_W-2:0], 1'b0}], mem_q[{raddr[ADDR_W-2:0], 1'b1}]};
        else
            rdata = {8'h00, mem_q[raddr]};
    end

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uwe_pkg::*;
#(
    parameter int BYTES       = 256,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    localparam int ADDR_W = $clog2(BYTES);
    localparam int SR_W   = ADDR_W + 18;
    localparam int CNT_W  = $clog2(SR_W + 1);
    localparam int CYC_W  = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        uwe_state_e        st;
        logic              sclk_prev;
        logic              cs_prev;
        logic [SR_W-1:0]   sr;
        logic [CNT_W-1:0]  cnt;
        uwe_op_e           pend;
        logic [ADDR_W-1:0] paddr;
        logic [15:0]       pdata;
        logic              wen;
        logic              status;
        logic              clr_pend;
        logic [CYC_W-1:0]  busy_cnt;
        logic [ADDR_W-1:0] raddr;
        logic [3:0]        rbit;
        logic              dout;
        logic              we;
        logic              we_all;
        logic [ADDR_W-1:0] waddr;
        logic [15:0]       wdata;
    } uwe_regs_t;

    uwe_regs_t q, d;

    logic [2:0]        sync_s;
    logic              cs_s, sclk_s, sdi_s;
    logic              wide, rise, cs_fall;
    logic              busy, in_read, fire, wen;
    logic [15:0]       rdata;
    logic [SR_W-1:0]   sr_nx;
    logic [CNT_W-1:0]  cnt_nx, n_cmd, n_all, dw;
    logic [3:0]        top_bit;
    logic [ADDR_W-1:0] a_raw, a_cmd, a_dat;

    uwe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, sdi_i}),
        .sync_o  (sync_s)
    );

    assign {cs_s, sclk_s, sdi_s} = sync_s;
    assign wide    = org_i;
    assign rise    = sclk_s & ~q.sclk_prev;
    assign cs_fall = q.cs_prev & ~cs_s;
    assign busy    = (q.busy_cnt != '0);
    assign in_read = (q.st == ST_READ);
    assign fire    = q.we | q.we_all;
    assign wen     = q.wen;

    uwe_store #(.BYTES(BYTES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wide   (wide),
        .we     (q.we),
        .we_all (q.we_all),
        .waddr  (q.waddr),
        .wdata  (q.wdata),
        .raddr  (q.raddr),
        .rdata  (rdata)
    );

    always_comb begin
        d           = q;
        d.we        = 1'b0;
        d.we_all    = 1'b0;
        d.sclk_prev = sclk_s;
        d.cs_prev   = cs_s;
        sr_nx       = {q.sr[SR_W-2:0], sdi_s};
        cnt_nx      = q.cnt + 1'b1;
        dw          = wide ? CNT_W'(16) : CNT_W'(8);
        top_bit     = wide ? 4'd15 : 4'd7;
        n_cmd       = wide ? CNT_W'(ADDR_W + 2) : CNT_W'(ADDR_W + 3);
        n_all       = n_cmd + dw;
        a_raw       = sr_nx[ADDR_W-1:0];
        a_cmd       = wide ? {1'b0, a_raw[ADDR_W-2:0]} : a_raw;
        a_raw       = sr_nx[dw +: ADDR_W];
        a_dat       = wide ? {1'b0, a_raw[ADDR_W-2:0]} : a_raw;

        if (busy) d.busy_cnt = q.busy_cnt - 1'b1;

        if (!cs_s) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            if (cs_fall) begin
                if (q.clr_pend) begin
                    d.status   = 1'b0;
                    d.clr_pend = 1'b0;
                end
                case (q.pend)
                    OP_NONE:    ;
                    OP_UNLOCK:  d.wen = 1'b1;
                    OP_LOCK:    d.wen = 1'b0;
                    default: begin
                        if (q.wen) begin
                            d.we       = (q.pend == OP_WIPE) || (q.pend == OP_PUT);
                            d.we_all   = (q.pend == OP_WIPE_ALL) || (q.pend == OP_PUT_ALL);
                            d.waddr    = q.paddr;
                            d.wdata    = ((q.pend == OP_WIPE) || (q.pend == OP_WIPE_ALL))
                                         ? 16'hFFFF : q.pdata;
                            d.busy_cnt = CYC_W'(PROG_CYCLES);
                            d.status   = 1'b1;
                        end
                    end
                endcase
                d.pend = OP_NONE;
            end
        end else if (rise) begin
            case (q.st)
                ST_IDLE: begin
                    if (sdi_s && !busy) begin
                        d.st  = ST_SHIFT;
                        d.cnt = '0;
                        d.sr  = '0;
                        if (q.status) d.clr_pend = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    d.sr  = sr_nx;
                    d.cnt = cnt_nx;
                    if (cnt_nx == n_cmd) begin
                        d.paddr = a_cmd;
                        case (sr_nx[n_cmd-1 -: 2])
                            2'b10: begin
                                d.st    = ST_READ;
                                d.raddr = a_cmd;
                                d.rbit  = top_bit;
                                d.dout  = 1'b0;
                            end
                            2'b11: begin
                                d.pend = OP_WIPE;
                                d.st   = ST_DONE;
                            end
                            2'b00: begin
                                case (sr_nx[n_cmd-3 -: 2])
                                    2'b11: begin d.pend = OP_UNLOCK;   d.st = ST_DONE; end
                                    2'b00: begin d.pend = OP_LOCK;     d.st = ST_DONE; end
                                    2'b10: begin d.pend = OP_WIPE_ALL; d.st = ST_DONE; end
                                    default: ;
                                endcase
                            end
                            default: ;
                        endcase
                    end else if (cnt_nx == n_all) begin
                        d.pdata = wide ? sr_nx[15:0] : {sr_nx[7:0], sr_nx[7:0]};
                        d.paddr = a_dat;
                        d.pend  = (sr_nx[n_all-1 -: 2] == 2'b01) ? OP_PUT : OP_PUT_ALL;
                        d.st    = ST_DONE;
                    end
                end
                ST_READ: begin
                    d.dout = rdata[q.rbit];
                    if (q.rbit == 4'd0) begin
                        d.rbit  = top_bit;
                        d.raddr = wide ? {1'b0, q.raddr[ADDR_W-2:0] + 1'b1} : q.raddr + 1'b1;
                    end else begin
                        d.rbit = q.rbit - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.pend <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign sdo_oe_o = cs_s & (in_read | q.status);
    assign sdo_o    = in_read ? q.dout : ~busy;

endmodule

// File: rtl/uwe_chk.sv
module uwe_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic in_read,
    input logic busy,
    input logic fire,
    input logic wen
);

    // R11
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !sdo_oe_o);

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_read) |-> (sdo_oe_o && !sdo_o));

    // R5
    locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(wen));

    // R9
    fire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> busy);

    // R9
    busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_read);

endmodule

bind uwire_eeprom uwe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .in_read  (in_read),
    .busy     (busy),
    .fire     (fire),
    .wen      (wen)
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;

    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b0;
    logic sdo, sdo_oe;
    int   checks = 0;
    int   errors = 0;
    logic s;
    logic [15:0] w;

    always #2 clk = ~clk;

    uwire_eeprom #(.PROG_CYCLES(PROG)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .org_i    (org),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    // {org, address, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 8'h00, 16'h003C},
        {1'b0, 8'hFF, 16'h00C3},
        {1'b0, 8'h81, 16'h0055},
        {1'b1, 8'h03, 16'hA55A},
        {1'b1, 8'h7F, 16'h1234},
        {1'b1, 8'h40, 16'hFFFE}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input logic b, output logic smp);
        sdi  = b;
        sclk = 1'b0;
        wait_n(5);
        sclk = 1'b1;
        wait_n(5);
        smp = sdo;
    endtask

    task automatic shift(input logic [31:0] v, input int n);
        logic t;
        for (int i = n - 1; i >= 0; i--) tick(v[i], t);
    endtask

    task automatic select();
        cs = 1'b1;
        wait_n(5);
    endtask

    task automatic deselect();
        sclk = 1'b0;
        sdi  = 1'b0;
        cs   = 1'b0;
        wait_n(8);
    endtask

    function automatic int aw();
        return org ? 8 : 9;
    endfunction

    function automatic int dwid();
        return org ? 16 : 8;
    endfunction

    function automatic logic [31:0] cmd(input logic [1:0] op, input logic [8:0] field);
        return (32'h1 << (aw() + 2)) | (32'(op) << aw()) | 32'(field);
    endfunction

    task automatic send_op(input logic [1:0] op, input logic [8:0] field,
                           input logic [15:0] data, input bit has_data);
        select();
        shift(cmd(op, field), aw() + 3);
        if (has_data) shift(32'(data), dwid());
        deselect();
    endtask

    task automatic prog_op(input logic [1:0] op, input logic [8:0] field,
                           input logic [15:0] data, input bit has_data);
        send_op(op, field, data, has_data);
        wait_n(PROG + 20);
    endtask

    task automatic sub_op(input logic [1:0] sub);
        send_op(2'b00, 9'(sub) << (aw() - 2), 16'h0, 1'b0);
    endtask

    task automatic rd_start(input logic [8:0] addr, input string tag);
        logic [31:0] v;
        v = cmd(2'b10, addr);
        select();
        shift(v >> 1, aw() + 2);
        tick(v[0], s);
        chk({tag, " dummy"}, {15'h0, s}, 16'h0);
    endtask

    task automatic rd_word(output logic [15:0] r);
        r = '0;
        for (int i = 0; i < dwid(); i++) begin
            tick(1'b0, s);
            r = {r[14:0], s};
        end
    endtask

    task automatic rd_one(input logic [8:0] addr, input logic [15:0] exp, input string tag);
        rd_start(addr, tag);
        rd_word(w);
        chk(tag, w, exp);
        deselect();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);

        // R11: output released after reset
        chk("R11 reset oe", {15'h0, sdo_oe}, 16'h0);
        // R8 R3: erased contents after reset
        rd_one(9'h000, 16'h00FF, "R8 reset byte0");

        // R5: locked store is ignored, no status
        send_op(2'b01, 9'h005, 16'h0011, 1'b1);
        select();
        chk("R5 locked no status", {15'h0, sdo_oe}, 16'h0);
        deselect();
        rd_one(9'h005, 16'h00FF, "R5 locked store");

        // R1: leading zero clocks before the unlock start bit
        select();
        shift(32'h0, 3);
        shift(cmd(2'b00, 9'(2'b11) << 7), 12);
        deselect();

        // R2 R6: vector table, store then read back
        for (int k = 0; k < 6; k++) begin
            org = VEC[k][24];
            wait_n(2);
            prog_op(2'b01, 9'(VEC[k][23:16]), VEC[k][15:0], 1'b1);
            rd_one(9'(VEC[k][23:16]), org ? VEC[k][15:0] : {8'h00, VEC[k][7:0]}, "R2 R6 vector");
        end

        // R8 R4: byte view of a wide word, streamed
        org = 1'b0;
        wait_n(2);
        rd_start(9'h006, "R8");
        rd_word(w);
        chk("R8 high byte", w, 16'h00A5);
        rd_word(w);
        chk("R4 R8 low byte", w, 16'h005A);
        deselect();

        // R9: busy indication, start ignored while busy
        send_op(2'b01, 9'h00A, 16'h0077, 1'b1);
        select();
        chk("R9 busy oe", {15'h0, sdo_oe}, 16'h1);
        chk("R9 busy level", {15'h0, sdo}, 16'h0);
        shift(cmd(2'b10, 9'h006), 12);
        tick(1'b0, s);
        chk("R9 start ignored while busy", {15'h0, s}, 16'h0);
        wait_n(PROG);
        chk("R9 ready level", {15'h0, sdo}, 16'h1);
        deselect();
        // R10: status survives a plain deselect, cleared by start then deselect
        select();
        chk("R10 status kept", {15'h0, sdo_oe}, 16'h1);
        tick(1'b1, s);
        deselect();
        select();
        chk("R10 status cleared", {15'h0, sdo_oe}, 16'h0);
        deselect();
        rd_one(9'h00A, 16'h0077, "R6 stored byte");

        // R4: wrap from last byte to first, 8-bit and 16-bit views
        rd_start(9'h0FF, "R4 x8");
        rd_word(w);
        chk("R4 x8 last", w, 16'h0034);
        rd_word(w);
        chk("R4 x8 wrap", w, 16'h003C);
        deselect();
        org = 1'b1;
        wait_n(2);
        rd_start(9'h07F, "R4 x16");
        rd_word(w);
        chk("R4 x16 last", w, 16'h1234);
        rd_word(w);
        chk("R4 x16 wrap", w, 16'h3CFF);
        deselect();

        // R6: clear word
        org = 1'b0;
        wait_n(2);
        prog_op(2'b11, 9'h000, 16'h0, 1'b0);
        rd_one(9'h000, 16'h00FF, "R6 clear word");

        // R6: truncated store discarded
        select();
        shift(cmd(2'b01, 9'h00A), 12);
        shift(32'h5, 4);
        deselect();
        select();
        chk("R6 partial no status", {15'h0, sdo_oe}, 16'h0);
        deselect();
        rd_one(9'h00A, 16'h0077, "R6 partial discarded");

        // R7: fill array in 16-bit mode
        org = 1'b1;
        wait_n(2);
        prog_op(2'b00, 9'(2'b01) << 6, 16'hBEEF, 1'b1);
        rd_one(9'h020, 16'hBEEF, "R7 fill word");
        org = 1'b0;
        wait_n(2);
        rd_one(9'h009, 16'h00EF, "R7 fill odd byte");

        // R7: clear array
        select();
        shift(cmd(2'b00, 9'(2'b10) << 7), 12);
        deselect();
        wait_n(PROG + 20);
        rd_one(9'h04D, 16'h00FF, "R7 clear array");

        // R5: lock again, store ignored, read still works
        sub_op(2'b00);
        prog_op(2'b01, 9'h003, 16'h0000, 1'b1);
        rd_one(9'h003, 16'h00FF, "R5 relock");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule